// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block maps addresses leaving a local bus onto a 64-bit PCI bus address space. The local space is split into a table of equal-size windows. Each window holds a 64-bit target offset and its own enable bit. The window for a request is picked straight from a bit field of the incoming address, so the path needs no base/limit comparators. The field's position moves with a shared power-of-two size code. The upper address bits are then swapped for the window's programmed offset.

Software programs the block through a simple word-addressed register port with combinational reads. A command word holds the global translation enable. A size word holds the 3-bit window-size code. Each window has a pair of offset words. One cycle after a request the block presents either a translated address with a valid strobe or a one-cycle miss flag. A region larger than one window is covered by programming consecutive windows with offsets that step by the window size.

Top module: `ob_window_xlat`

## Requirements
- R1: After reset the global enable, the size code and every window's low and high offset words read as zero, and no valid or miss strobe is raised.
- R2: Register offsets (byte addresses, word aligned) are: command word at 0x004, where only bit 1 (global enable) is stored and the other bits read zero; size word at 0x030, where only bits [2:0] (size code k) are stored; window n low word at 0x200 + 8*n and high word at 0x204 + 8*n, both storing all 32 bits. Reads return the stored values.
- R3: With size code k, the window size is 2^(20+k) bytes and the window index is address bits [24+k:20+k]; address bits above that field do not affect the result.
- R4: A request to an enabled window, while the global enable is set, raises out_valid for one cycle on the clock edge after the request. out_addr is then {high word, low word with bit 0 cleared} plus the request address modulo the window size.
- R5: Bit 0 of a window's low word is its enable. A request to a window whose enable is clear raises out_miss for one cycle on the next edge, with out_valid low and out_addr zero.
- R6: While the global enable is clear, every request misses, whatever the window enables are.
- R7: out_valid and out_miss are never high together, and neither rises unless a request was presented on the previous cycle.
- R8: Writes to offsets that are not mapped, or that are not word aligned, change no stored register, and unmapped offsets read zero.
- R9: Consecutive windows programmed with offsets stepping by the window size translate a span that crosses a window boundary into one contiguous PCI address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| in_valid | input | 1 | Translation request strobe |
| in_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Translated address valid (one cycle) |
| out_addr | output | 64 | Translated PCI address, zero when not valid |
| out_miss | output | 1 | Request hit a disabled window or translation is off (one cycle) |

## Verification
On every cycle the assertions check the strobe protocol: valid and miss are exclusive, each answers a request from the cycle before, and every request is answered. They also check that a request made while the global enable is clear misses, and that the address output is zero whenever it is not valid. The translated values themselves, the choice of index field for each size code, register readback, the ignoring of stray writes and contiguity across windows can only be shown by the bench's sweeps. The bench computes the expected addresses arithmetically for every window at every size code.

// File: rtl/ob_window_xlat.sv
module ob_window_xlat #(
  parameter int NUM_WIN    = 32,
  parameter int ADDR_W     = 32,
  parameter int BASE_SHIFT = 20,
  parameter int SIZE_W     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic        out_valid,
  output logic [63:0] out_addr,
  output logic        out_miss
);
  localparam int IW = $clog2(NUM_WIN);
  localparam logic [11:0] CMD_OFS  = 12'h004;
  localparam logic [11:0] SIZE_OFS = 12'h030;

  logic [31:0]       lo_q [NUM_WIN];
  logic [31:0]       hi_q [NUM_WIN];
  logic              xlat_en_q;
  logic [SIZE_W-1:0] size_q;

  wire          win_reg = (reg_addr[11:9] == 3'b001) && (reg_addr[1:0] == 2'b00)
                          && ({1'b0, reg_addr[8:3]} < 7'(NUM_WIN));
  wire [IW-1:0] reg_win = reg_addr[3 +: IW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlat_en_q <= 1'b0;
      size_q    <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == CMD_OFS)  xlat_en_q <= reg_wdata[1];
      if (reg_addr == SIZE_OFS) size_q    <= reg_wdata[SIZE_W-1:0];
      if (win_reg) begin
        if (reg_addr[2]) hi_q[reg_win] <= reg_wdata;
        else             lo_q[reg_win] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CMD_OFS)  reg_rdata = {30'd0, xlat_en_q, 1'b0};
    if (reg_addr == SIZE_OFS) reg_rdata = 32'(size_q);
    if (win_reg)              reg_rdata = reg_addr[2] ? hi_q[reg_win] : lo_q[reg_win];
  end

  wire [5:0]    sh    = 6'(BASE_SHIFT) + 6'(size_q);
  wire [IW-1:0] idx   = IW'(in_addr >> sh);
  wire [63:0]   lowp  = 64'(in_addr) & ((64'd1 << sh) - 64'd1);
  wire [63:0]   base  = {hi_q[idx], lo_q[idx][31:1], 1'b0};
  wire          hit   = xlat_en_q & lo_q[idx][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid & hit;
      out_miss  <= in_valid & ~hit;
      out_addr  <= (in_valid & hit) ? base + lowp : '0;
    end
  end
endmodule

module ob_window_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic        out_miss,
  input logic [63:0] out_addr,
  input logic        xlat_en_q
);
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_miss)); // R7
  AST_STROBE_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_miss) |-> $past(in_valid)); // R7
  AST_REQUEST_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid || out_miss)); // R4
  AST_GLOBAL_OFF_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !xlat_en_q) |=> out_miss); // R6
  AST_ADDR_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_addr == 64'd0); // R5
endmodule

bind ob_window_xlat ob_window_xlat_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_miss(out_miss), .out_addr(out_addr), .xlat_en_q(xlat_en_q)
);

// File: tb/test_ob_window_xlat.sv
module test_ob_window_xlat;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic        out_miss;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ob_window_xlat i_ob_window_xlat (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic xl(logic [31:0] a);
    @(negedge clk); in_valid = 1; in_addr = a;
    @(negedge clk); in_valid = 0;
  endtask

  function automatic logic [31:0] lo_val(int n);
    return (32'(n) * 32'h0013_0000) ^ 32'hA5A0_0000 ^ 32'(n % 3 != 0);
  endfunction
  function automatic logic [31:0] hi_val(int n);
    return 32'h100 + 32'(n);
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(out_valid), 0);
    chk("R1 miss", 64'(out_miss), 0);
    rd(12'h004, d); chk("R1 cmd", 64'(d), 0);
    rd(12'h030, d); chk("R1 size", 64'(d), 0);
    for (int n = 0; n < 32; n++) begin
      rd(12'(12'h200 + 8*n), d); chk("R1 lo", 64'(d), 0);
      rd(12'(12'h204 + 8*n), d); chk("R1 hi", 64'(d), 0);
    end
    xl(32'h0030_0000);
    chk("R1 miss after reset", 64'(out_miss), 1);

    // R2 readback
    for (int n = 0; n < 32; n++) begin
      wr(12'(12'h200 + 8*n), lo_val(n));
      wr(12'(12'h204 + 8*n), hi_val(n));
    end
    for (int n = 0; n < 32; n++) begin
      rd(12'(12'h200 + 8*n), d); chk("R2 lo", 64'(d), 64'(lo_val(n)));
      rd(12'(12'h204 + 8*n), d); chk("R2 hi", 64'(d), 64'(hi_val(n)));
    end
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, d); chk("R2 size", 64'(d), 7);
    wr(12'h030, 32'h0);
    rd(12'h030, d); chk("R2 size clr", 64'(d), 0);

    // R6 global enable clear: enabled window 1 still misses
    xl(32'h0010_0000);
    chk("R6 miss", 64'(out_miss), 1);
    chk("R6 valid", 64'(out_valid), 0);
    chk("R6 addr", out_addr, 0);

    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R2 cmd", 64'(d), 2);

    // R8 stray writes
    wr(12'h300, 32'hDEAD_BEEF);
    wr(12'h008, 32'hDEAD_BEEF);
    wr(12'h201, 32'hDEAD_BEEF);
    wr(12'h206, 32'hDEAD_BEEF);
    rd(12'h300, d); chk("R8 unmapped read", 64'(d), 0);
    rd(12'h008, d); chk("R8 unmapped read", 64'(d), 0);
    rd(12'h200, d); chk("R8 lo0 kept", 64'(d), 64'(lo_val(0)));
    rd(12'h204, d); chk("R8 hi0 kept", 64'(d), 64'(hi_val(0)));
    rd(12'h030, d); chk("R8 size kept", 64'(d), 0);

    // R3/R4/R5 sweep over size codes and windows
    for (int k = 0; k < 8; k++) begin
      wr(12'h030, 32'(k));
      for (int n = 0; n < 32; n++) begin
        logic [63:0] mask, off, noise, a64, exp;
        mask  = (64'd1 << (20 + k)) - 1;
        off   = (64'(n) * 64'h1_3579 + 64'(k) * 64'h9) & mask;
        noise = (64'hFFFF_FFFF << (25 + k)) & 64'hAAAA_AAAA;
        a64   = (64'(n) << (20 + k)) | off | noise;
        xl(a64[31:0]);
        if (n % 3 != 0) begin
          exp = {hi_val(n), lo_val(n) & 32'hFFFF_FFFE} + off;
          chk("R4 valid", 64'(out_valid), 1);
          chk("R3 R4 addr", out_addr, exp);
        end else begin
          chk("R5 miss", 64'(out_miss), 1);
          chk("R5 valid low", 64'(out_valid), 0);
          chk("R5 addr zero", out_addr, 0);
        end
      end
    end

    // R9 contiguous span over windows 4..7 at 1 MB
    wr(12'h030, 32'h0);
    for (int i = 0; i < 4; i++) begin
      wr(12'(12'h200 + 8*(4+i)), 32'h8000_0000 + 32'(i) * 32'h0010_0000 + 1);
      wr(12'(12'h204 + 8*(4+i)), 32'h0000_0002);
    end
    for (int j = 0; j < 8; j++) begin
      logic [31:0] a;
      a = 32'h004F_FFF8 + 32'(j) * 4;
      xl(a);
      chk("R9 contiguous", out_addr, 64'h2_8000_0000 + 64'(a - 32'h0040_0000));
    end
    for (int i = 1; i < 4; i++) begin
      xl(32'h0040_0000 + 32'(i) * 32'h0010_0000);
      chk("R9 boundary", out_addr, 64'h2_8000_0000 + 64'(i) * 64'h10_0000);
    end

    // R7 strobes quiet without requests
    @(negedge clk);
    chk("R7 idle valid", 64'(out_valid), 0);
    chk("R7 idle miss", 64'(out_miss), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule